// File: doc/BRIEF.md
# CPU exception entry controller

This block decides, at each instruction-block boundary of a small CPU core, whether the core enters an exception handler, and which kind of entry it makes. It watches a level-sensitive maskable interrupt request with its vector and a non-maskable interrupt request. It also takes a break/trap request, and keeps a record of a pending bus fault reported by the memory system together with its handler vector. From the current program counter and the condition-code status register it produces, for the chosen entry, a one-cycle strobe, the kind code and the handler vector. It also gives the write enables and values for the two return-address registers and the updated status word.

The non-maskable interrupt has its own enable flag in the status register. It always goes to vector zero and saves its return address in a dedicated register. Taking it clears its enable flag, so a second one cannot nest until software sets the flag again. Bus faults, breaks and maskable interrupts all share the exception return register. A break saves the address of the following instruction. If a second bus fault is reported while one is still pending, no further entries are made. A sticky fatal output is raised instead, and only reset clears it.

All decisions are registered. Inputs sampled at a clock edge produce their outputs during the following cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous active-high reset drives every output to zero on the next edge and clears the pending bus fault and the fatal state.
- R2: `take` is high for exactly the one cycle after the edge at which an entry was decided. `kind`, `vec`, both return-register writes and the status outputs are valid in that cycle only and are zero otherwise. `kind` is encoded as 1 non-maskable interrupt, 3 bus fault, 4 maskable interrupt, 5 break, and 0 when `take` is low.
- R3: A maskable interrupt (`irq_req`) is taken only when status bit I_BIT (default 4) is set. Its vector is `irq_vec`, and it writes `pc` into the exception return register (`erp_we`/`erp_val`).
- R4: A non-maskable interrupt (`nmi_req`) is taken only when status bit M_BIT (bit 30) is set. It uses vector 0 and writes `pc` into the NMI return register (`nrp_we`/`nrp_val`). It asserts `ccs_we`, with `ccs_out` equal to `ccs_in` with bit 30 cleared and every other bit unchanged, including the Q flag at bit 31.
- R5: `bfault_req` latches a pending bus fault and its `bfault_vec`. The fault is taken at the first boundary after the edge that latched it, with the latched vector and `erp_val` = `pc`, and taking it clears the pending state.
- R6: A break (`brk_req`) writes `pc` + 2 into the exception return register, with vector 0.
- R7: Among candidates present at one boundary, the order is: pending bus fault, then break, then enabled non-maskable interrupt, then enabled maskable interrupt. A request that loses is not remembered.
- R8: A `bfault_req` that arrives while a bus fault is already pending sets `fatal` on the next edge and suppresses the entry that edge would have made. `fatal` then stays high and no entry is taken until reset.
- R9: No entry is taken at an edge where `boundary` is low. `ccs_we` is high only for non-maskable interrupt entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction-block boundary; pc is valid |
| irq_req | input | 1 | Maskable interrupt request (level) |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| bfault_req | input | 1 | Bus fault report (one cycle per fault) |
| bfault_vec | input | VEC_W | Handler vector of the reported fault |
| brk_req | input | 1 | Break/trap request at this boundary |
| pc | input | XLEN | Current program counter |
| ccs_in | input | XLEN | Current condition-code status register |
| take | output | 1 | Exception entry strobe |
| kind | output | 3 | Kind code of the entry |
| vec | output | VEC_W | Handler vector |
| erp_we | output | 1 | Write enable, exception return register |
| erp_val | output | XLEN | Value for the exception return register |
| nrp_we | output | 1 | Write enable, NMI return register |
| nrp_val | output | XLEN | Value for the NMI return register |
| ccs_we | output | 1 | Write enable, status register |
| ccs_out | output | XLEN | Updated status register value |
| fatal | output | 1 | Recursive bus fault, sticky until reset |

## Verification
The hardest state to reach is a second fault report while a first is still pending. It needs a fault to be latched and then reported again before any boundary consumes it, and it must also be tried on a cycle where a boundary with other candidates is present. The directed stimulus builds this by holding `boundary` low between two reports, and again by reporting a second fault on a boundary cycle with an enabled interrupt. A long random phase with sparse fault reports then reaches it by chance, resets, and carries on. The same-boundary contests between fault, break and both interrupts are covered by directed cases that present all of them together and then remove them one at a time.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        EXC_NONE   = 3'd0,
        EXC_NMI    = 3'd1,
        EXC_FATAL  = 3'd2,
        EXC_BFAULT = 3'd3,
        EXC_IRQ    = 3'd4,
        EXC_BRK    = 3'd5
    } exc_kind_e;
endpackage

// File: rtl/exc_fault_track.sv
module exc_fault_track #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bfault_req,
    input  logic [VEC_W-1:0] bfault_vec,
    input  logic             consume,
    output logic             pend,
    output logic [VEC_W-1:0] pend_vec,
    output logic             fatal,
    output logic             halt
);
    typedef struct packed {
        logic             pend;
        logic [VEC_W-1:0] vec;
        logic             fatal;
    } trk_t;

    trk_t st_d, st_q;
    logic nested;

    always_comb begin
        nested = bfault_req && st_q.pend && !st_q.fatal;
        st_d   = st_q;
        if (!st_q.fatal) begin
            if (nested) begin
                st_d.fatal = 1'b1;
            end else if (bfault_req) begin
                st_d.pend = 1'b1;
                st_d.vec  = bfault_vec;
            end else if (consume) begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend     = st_q.pend;
    assign pend_vec = st_q.vec;
    assign fatal    = st_q.fatal;
    assign halt     = st_q.fatal || nested;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      boundary,
    input  logic      halt,
    input  logic      bf_pend,
    input  logic      brk_req,
    input  logic      nmi_ok,
    input  logic      irq_ok,
    output exc_kind_e sel
);
    always_comb begin
        sel = EXC_NONE;
        if (boundary && !halt) begin
            if (bf_pend)      sel = EXC_BFAULT;
            else if (brk_req) sel = EXC_BRK;
            else if (nmi_ok)  sel = EXC_NMI;
            else if (irq_ok)  sel = EXC_IRQ;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int VEC_W   = 8,
    parameter int I_BIT   = 4,
    parameter int M_BIT   = 30,
    parameter int BRK_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              nmi_req,
    input  logic              bfault_req,
    input  logic [VEC_W-1:0]  bfault_vec,
    input  logic              brk_req,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   ccs_in,
    output logic              take,
    output logic [KIND_W-1:0] kind,
    output logic [VEC_W-1:0]  vec,
    output logic              erp_we,
    output logic [XLEN-1:0]   erp_val,
    output logic              nrp_we,
    output logic [XLEN-1:0]   nrp_val,
    output logic              ccs_we,
    output logic [XLEN-1:0]   ccs_out,
    output logic              fatal
);
    localparam logic [XLEN-1:0] M_MASK  = XLEN'(1) << M_BIT;
    localparam logic [XLEN-1:0] BRK_ADV = XLEN'(BRK_LEN);

    typedef struct packed {
        logic              take;
        logic [KIND_W-1:0] kind;
        logic [VEC_W-1:0]  vec;
        logic              erp_we;
        logic [XLEN-1:0]   erp_val;
        logic              nrp_we;
        logic [XLEN-1:0]   nrp_val;
        logic              ccs_we;
        logic [XLEN-1:0]   ccs_out;
    } entry_t;

    entry_t      ent_d, ent_q;
    exc_kind_e   sel;
    logic        bf_pend, halt, consume;
    logic [VEC_W-1:0] bf_vec;

    exc_fault_track #(.VEC_W(VEC_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .bfault_req (bfault_req),
        .bfault_vec (bfault_vec),
        .consume    (consume),
        .pend       (bf_pend),
        .pend_vec   (bf_vec),
        .fatal      (fatal),
        .halt       (halt)
    );

    exc_arbiter u_arb (
        .boundary (boundary),
        .halt     (halt),
        .bf_pend  (bf_pend),
        .brk_req  (brk_req),
        .nmi_ok   (nmi_req && ccs_in[M_BIT]),
        .irq_ok   (irq_req && ccs_in[I_BIT]),
        .sel      (sel)
    );

    assign consume = (sel == EXC_BFAULT);

    always_comb begin
        ent_d      = '0;
        ent_d.kind = sel;
        ent_d.take = (sel != EXC_NONE);
        if (sel != EXC_NONE) ent_d.ccs_out = ccs_in;
        case (sel)
            EXC_BFAULT: begin
                ent_d.vec     = bf_vec;
                ent_d.erp_we  = 1'b1;
                ent_d.erp_val = pc;
            end
            EXC_BRK: begin
                ent_d.erp_we  = 1'b1;
                ent_d.erp_val = pc + BRK_ADV;
            end
            EXC_NMI: begin
                ent_d.nrp_we  = 1'b1;
                ent_d.nrp_val = pc;
                ent_d.ccs_we  = 1'b1;
                ent_d.ccs_out = ccs_in & ~M_MASK;
            end
            EXC_IRQ: begin
                ent_d.vec     = irq_vec;
                ent_d.erp_we  = 1'b1;
                ent_d.erp_val = pc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ent_q <= '0;
        else     ent_q <= ent_d;
    end

    assign take    = ent_q.take;
    assign kind    = ent_q.kind;
    assign vec     = ent_q.vec;
    assign erp_we  = ent_q.erp_we;
    assign erp_val = ent_q.erp_val;
    assign nrp_we  = ent_q.nrp_we;
    assign nrp_val = ent_q.nrp_val;
    assign ccs_we  = ent_q.ccs_we;
    assign ccs_out = ent_q.ccs_out;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN    = 32,
    parameter int VEC_W   = 8,
    parameter int I_BIT   = 4,
    parameter int M_BIT   = 30,
    parameter int BRK_LEN = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             boundary,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             nmi_req,
    input logic             bfault_req,
    input logic [VEC_W-1:0] bfault_vec,
    input logic             brk_req,
    input logic [XLEN-1:0]  pc,
    input logic [XLEN-1:0]  ccs_in,
    input logic             take,
    input logic [2:0]       kind,
    input logic [VEC_W-1:0] vec,
    input logic             erp_we,
    input logic [XLEN-1:0]  erp_val,
    input logic             nrp_we,
    input logic [XLEN-1:0]  nrp_val,
    input logic             ccs_we,
    input logic [XLEN-1:0]  ccs_out,
    input logic             fatal
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !take && !fatal && !erp_we && !nrp_we && !ccs_we);

    a_r2_kind_with_take: assert property (@(posedge clk) disable iff (rst)
        (kind != 3'd0) |-> take);

    a_r3_irq_enabled: assert property (@(posedge clk) disable iff (rst)
        (take && kind == 3'd4) |-> $past(ccs_in[I_BIT]) && $past(irq_req)
                                   && vec == $past(irq_vec) && erp_val == $past(pc));

    a_r4_nmi_entry: assert property (@(posedge clk) disable iff (rst)
        (take && kind == 3'd1) |-> $past(ccs_in[M_BIT]) && vec == '0 && nrp_we
                                   && nrp_val == $past(pc) && ccs_we && !ccs_out[M_BIT]);

    a_r5_bfault_ret: assert property (@(posedge clk) disable iff (rst)
        (take && kind == 3'd3) |-> erp_we && erp_val == $past(pc));

    a_r6_brk_ret: assert property (@(posedge clk) disable iff (rst)
        (take && kind == 3'd5) |-> erp_we && erp_val == $past(pc) + XLEN'(BRK_LEN));

    a_r7_irq_lowest: assert property (@(posedge clk) disable iff (rst)
        (take && kind == 3'd4) |-> !$past(brk_req) && !$past(nmi_req && ccs_in[M_BIT]));

    a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal && !take);

    a_r8_fatal_blocks: assert property (@(posedge clk) disable iff (rst)
        fatal |-> !take);

    a_r9_on_boundary: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(boundary));

    a_r9_one_ret_reg: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erp_we, nrp_we}));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .VEC_W(VEC_W), .I_BIT(I_BIT), .M_BIT(M_BIT), .BRK_LEN(BRK_LEN)
) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int VEC_W = 8;
    localparam int IB    = 4;
    localparam int MB    = 30;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst, boundary, irq_req, nmi_req, bfault_req, brk_req;
    logic [VEC_W-1:0] irq_vec, bfault_vec;
    logic [XLEN-1:0]  pc, ccs_in;
    logic take, erp_we, nrp_we, ccs_we, fatal;
    logic [2:0] kind;
    logic [VEC_W-1:0] vec;
    logic [XLEN-1:0] erp_val, nrp_val, ccs_out;

    exc_entry_ctrl dut (
        .clk(clk), .rst(rst), .boundary(boundary), .irq_req(irq_req), .irq_vec(irq_vec),
        .nmi_req(nmi_req), .bfault_req(bfault_req), .bfault_vec(bfault_vec),
        .brk_req(brk_req), .pc(pc), .ccs_in(ccs_in), .take(take), .kind(kind),
        .vec(vec), .erp_we(erp_we), .erp_val(erp_val), .nrp_we(nrp_we),
        .nrp_val(nrp_val), .ccs_we(ccs_we), .ccs_out(ccs_out), .fatal(fatal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    bit m_pend, m_fatal, started;
    logic [VEC_W-1:0] m_pvec;
    logic e_take, e_erp_we, e_nrp_we, e_ccs_we, e_fatal;
    logic [2:0] e_kind;
    logic [VEC_W-1:0] e_vec;
    logic [XLEN-1:0] e_erp_val, e_nrp_val, e_ccs_out;
    string tag;
    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) begin
        bit nested;
        int cands;
        started = 1;
        cyc++;
        e_take = 0; e_kind = 0; e_vec = 0; e_erp_we = 0; e_erp_val = 0;
        e_nrp_we = 0; e_nrp_val = 0; e_ccs_we = 0; e_ccs_out = 0;
        cands = int'(m_pend) + int'(brk_req) + int'(nmi_req && ccs_in[MB]) + int'(irq_req && ccs_in[IB]);
        if (rst) begin
            m_pend = 0; m_fatal = 0; m_pvec = 0;
            tag = "R1";
        end else begin
            nested = bfault_req && m_pend && !m_fatal;
            tag = boundary ? ((cands > 1) ? "R7" : "R2") : "R9";
            if (boundary && !m_fatal && !nested) begin
                if (m_pend) begin
                    e_kind = 3; e_vec = m_pvec; e_erp_we = 1; e_erp_val = pc; tag = "R5";
                end else if (brk_req) begin
                    e_kind = 5; e_erp_we = 1; e_erp_val = pc + 2; tag = (cands > 1) ? "R7" : "R6";
                end else if (nmi_req && ccs_in[MB]) begin
                    e_kind = 1; e_nrp_we = 1; e_nrp_val = pc; e_ccs_we = 1;
                    tag = (cands > 1) ? "R7" : "R4";
                end else if (irq_req && ccs_in[IB]) begin
                    e_kind = 4; e_vec = irq_vec; e_erp_we = 1; e_erp_val = pc; tag = "R3";
                end
                if (e_kind != 0) begin
                    e_take = 1;
                    e_ccs_out = ccs_in;
                    if (e_kind == 1) e_ccs_out[MB] = 1'b0;
                end
            end
            if (!m_fatal) begin
                if (nested) m_fatal = 1;
                else if (bfault_req) begin m_pend = 1; m_pvec = bfault_vec; end
                else if (e_kind == 3) m_pend = 0;
            end
            if (m_fatal) tag = "R8";
        end
        e_fatal = m_fatal;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if ({take, kind, vec, erp_we, erp_val, nrp_we, nrp_val, ccs_we, ccs_out, fatal} !==
                {e_take, e_kind, e_vec, e_erp_we, e_erp_val, e_nrp_we, e_nrp_val, e_ccs_we, e_ccs_out, e_fatal}) begin
                n_bad++;
                $display("FAIL %s t=%0t got take=%b kind=%0d vec=%h erp=%b/%h nrp=%b/%h ccs=%b/%h fatal=%b exp take=%b kind=%0d vec=%h erp=%b/%h nrp=%b/%h ccs=%b/%h fatal=%b",
                    tag, $time, take, kind, vec, erp_we, erp_val, nrp_we, nrp_val, ccs_we, ccs_out, fatal,
                    e_take, e_kind, e_vec, e_erp_we, e_erp_val, e_nrp_we, e_nrp_val, e_ccs_we, e_ccs_out, e_fatal);
            end
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles, expected end before %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic drive(input bit b, input bit ir, input logic [VEC_W-1:0] iv, input bit nm,
                         input bit bf, input logic [VEC_W-1:0] bv, input bit bk,
                         input logic [XLEN-1:0] p, input logic [XLEN-1:0] c);
        boundary = b; irq_req = ir; irq_vec = iv; nmi_req = nm; bfault_req = bf;
        bfault_vec = bv; brk_req = bk; pc = p; ccs_in = c;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    endtask

    task automatic do_reset();
        rst = 1; idle(); idle(); rst = 0;
    endtask

    localparam logic [XLEN-1:0] CC_BOTH = 32'hC000_0010; // Q, M, I set
    localparam logic [XLEN-1:0] CC_NONE = 32'h8000_0000; // Q only

    initial begin
        rst = 1;
        boundary = 0; irq_req = 0; irq_vec = 0; nmi_req = 0; bfault_req = 0;
        bfault_vec = 0; brk_req = 0; pc = 0; ccs_in = 0;
        @(negedge clk);
        do_reset();                                             // R1
        drive(1, 1, 8'h21, 0, 0, 0, 0, 32'h100, CC_NONE);       // R3 masked
        drive(1, 1, 8'h21, 0, 0, 0, 0, 32'h104, CC_BOTH);       // R3 taken
        drive(0, 1, 8'h22, 1, 0, 0, 1, 32'h108, CC_BOTH);       // R9 no boundary
        drive(1, 0, 0, 1, 0, 0, 0, 32'h10C, CC_NONE);           // R4 masked
        drive(1, 0, 0, 1, 0, 0, 0, 32'h110, CC_BOTH);           // R4 taken, Q kept
        drive(1, 1, 8'h33, 1, 0, 0, 0, 32'h114, CC_BOTH);       // R7 nmi over irq
        drive(1, 1, 8'h33, 0, 0, 0, 0, 32'h118, CC_BOTH);       // irq held, taken later
        drive(1, 0, 0, 0, 0, 0, 1, 32'h11C, CC_NONE);           // R6 break
        drive(1, 1, 8'h44, 1, 0, 0, 1, 32'h120, CC_BOTH);       // R7 break first
        drive(1, 1, 8'h55, 0, 1, 8'h9A, 0, 32'h124, CC_BOTH);   // R5 latch, irq now
        drive(1, 1, 8'h55, 1, 0, 0, 1, 32'h128, CC_BOTH);       // R5/R7 fault first
        drive(0, 0, 0, 0, 1, 8'h3C, 0, 32'h12C, CC_BOTH);       // R5 latch off boundary
        idle();
        drive(1, 0, 0, 0, 0, 0, 0, 32'h130, CC_BOTH);           // R5 taken
        drive(0, 0, 0, 0, 1, 8'h11, 0, 32'h134, CC_BOTH);       // latch
        drive(0, 0, 0, 0, 1, 8'h12, 0, 32'h138, CC_BOTH);       // R8 nested
        drive(1, 1, 8'h66, 1, 0, 0, 1, 32'h13C, CC_BOTH);       // R8 blocked
        drive(1, 1, 8'h66, 0, 0, 0, 0, 32'h140, CC_BOTH);
        do_reset();                                             // R1 clears fatal
        drive(0, 0, 0, 0, 1, 8'h21, 0, 32'h200, CC_BOTH);
        drive(1, 1, 8'h77, 1, 1, 8'h22, 0, 32'h204, CC_BOTH);   // R8 on boundary
        idle();
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if (m_fatal && ($urandom % 4 == 0)) do_reset();
            else drive(($urandom % 3) != 0, $urandom % 2 == 0, 8'($urandom),
                       $urandom % 3 == 0, $urandom % 12 == 0, 8'($urandom),
                       $urandom % 5 == 0, {$urandom} & 32'hFFFF_FFFE,
                       {$urandom} & 32'hC000_00FF);
        end
        idle();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule